// File: doc/BRIEF.md
# Indirect Byte Register Access Bridge

This block lets a host with a single 64-bit command register reach a small file of 8-bit controller registers. The host writes one command word that carries a start flag, an operation code, a register index, a direction flag and a data byte. For an access command the bridge issues one byte-wide read or write on its internal register port. It then lowers the start flag so that the host can see the access has finished.

For a read, the fetched byte replaces the data field of the command word. The host does not get a direct bus response. It polls the command word until the start flag reads back low, then takes the result from that same word. Host writes that arrive while an access is still running are dropped. Reading the command word is a plain combinational view of the stored fields.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset the command word reads back as all zeros, and neither internal strobe (reg_wr, reg_rd) is asserted.
- R2: The command word layout is: start flag at bit 63, operation code at bits 62:60, direction flag at bit 56 (1 = read), register index at bits 42:40 and data byte at bits 7:0. All other bits read back as 0.
- R3: A host write with the start flag set and operation code 6 starts an access. The start flag reads back as 1 during the two clock cycles that follow the write edge, and reads 0 from the third cycle on.
- R4: In an access with the direction flag at 0, reg_wr is high for exactly the first cycle after the write edge, with reg_sel equal to the index and reg_wdata equal to the data byte. The data field keeps the written byte.
- R5: In an access with the direction flag at 1, reg_rd is high for exactly the first cycle after the write edge, with reg_sel equal to the index. The byte presented on reg_rdata in the second cycle is stored into bits 7:0 of the command word.
- R6: A host write with the start flag set and any operation code other than 6 starts no internal access. From the next cycle the start flag reads 0 and the data field reads 0, while the operation code, direction and index fields hold the written values.
- R7: A host write with the start flag at 0 stores the fields as written, including the data byte, and starts no internal access.
- R8: A host write that arrives while the start flag reads 1 is ignored and leaves every field of the running command unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word as read back by the host |
| reg_sel | output | 3 | Internal register index |
| reg_wr | output | 1 | Internal register write strobe |
| reg_rd | output | 1 | Internal register read strobe |
| reg_wdata | output | 8 | Byte written to the internal register |
| reg_rdata | input | 8 | Byte returned by the internal register, one cycle after reg_rd |

## Verification
A host write is sampled at clock edge E0. The strobe and the raised start flag are visible in the cycle after E0. The start flag stays high in the next cycle. The finished word, with the start flag low and any read byte in place, appears after the second edge following E0. A non-access command or a write without the start flag shows its final word in the very first cycle after E0. The bench drives on falling edges and samples on the falling edge of each of those cycles. Its own byte-register model responds to the strobes one edge later, as a real controller would. Expected words and register contents come from bench functions and a shadow copy of the register file.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int WORD_W    = 64,
  parameter int IDX_W     = 3,
  parameter int OP_W      = 3,
  parameter int OP_ACCESS = 6,
  parameter int VLD_BIT   = 63,
  parameter int OP_LSB    = 60,
  parameter int RD_BIT    = 56,
  parameter int IDX_LSB   = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic [IDX_W-1:0]  reg_sel,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata
);
  localparam logic [1:0] PH_IDLE = 2'd0, PH_ISSUE = 2'd1, PH_TAKE = 2'd2;

  logic             vld_q, rd_q;
  logic [OP_W-1:0]  op_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       dat_q;
  logic [1:0]       ph_q;

  wire              w_vld = host_wdata[VLD_BIT];
  wire [OP_W-1:0]   w_op  = host_wdata[OP_LSB +: OP_W];
  wire              take  = host_we && !vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0; rd_q <= 1'b0; op_q <= '0; idx_q <= '0; dat_q <= '0; ph_q <= PH_IDLE;
    end else if (take) begin
      op_q  <= w_op;
      rd_q  <= host_wdata[RD_BIT];
      idx_q <= host_wdata[IDX_LSB +: IDX_W];
      if (w_vld && w_op == OP_W'(OP_ACCESS)) begin
        vld_q <= 1'b1; dat_q <= host_wdata[7:0]; ph_q <= PH_ISSUE;
      end else begin
        vld_q <= 1'b0; dat_q <= w_vld ? 8'h00 : host_wdata[7:0]; ph_q <= PH_IDLE;
      end
    end else if (ph_q == PH_ISSUE) begin
      ph_q <= PH_TAKE;
    end else if (ph_q == PH_TAKE) begin
      ph_q  <= PH_IDLE;
      vld_q <= 1'b0;
      if (rd_q) dat_q <= reg_rdata;
    end
  end

  assign reg_sel   = idx_q;
  assign reg_wdata = dat_q;
  assign reg_wr    = (ph_q == PH_ISSUE) && !rd_q;
  assign reg_rd    = (ph_q == PH_ISSUE) && rd_q;

  always_comb begin
    host_rdata = '0;
    host_rdata[VLD_BIT]             = vld_q;
    host_rdata[OP_LSB +: OP_W]      = op_q;
    host_rdata[RD_BIT]              = rd_q;
    host_rdata[IDX_LSB +: IDX_W]    = idx_q;
    host_rdata[7:0]                 = dat_q;
  end

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdata[VLD_BIT] |-> !(reg_wr || reg_rd));
  p_busy_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdata[VLD_BIT]) |=> host_rdata[VLD_BIT] ##1 !host_rdata[VLD_BIT]);
  p_start_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rdata[VLD_BIT]) |-> (reg_wr || reg_rd));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdata[VLD_BIT] && host_we) |=> $stable(host_rdata[WORD_W-2:8]));
  p_other_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_rdata[VLD_BIT] && host_wdata[VLD_BIT] && host_wdata[OP_LSB +: OP_W] != OP_W'(OP_ACCESS))
    |=> (!host_rdata[VLD_BIT] && host_rdata[7:0] == 8'h00 && !reg_wr && !reg_rd));
endmodule

// File: tb/tb_ind_reg_bridge.sv
module tb_ind_reg_bridge;
  logic clk = 1'b0, rst_n = 1'b0, host_we = 1'b0;
  logic [63:0] host_wdata = '0, host_rdata;
  logic [2:0] reg_sel;
  logic reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  int checks = 0, fails = 0;
  logic [7:0] rf [8];
  logic [7:0] shadow [8];

  always #10 clk = ~clk;

  ind_reg_bridge dut (.clk, .rst_n, .host_we, .host_wdata, .host_rdata,
    .reg_sel, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata);

  always @(posedge clk) begin
    if (reg_wr) rf[reg_sel] <= reg_wdata;
    if (reg_rd) reg_rdata <= rf[reg_sel];
  end

  function automatic logic [63:0] mk(input logic v, input logic [2:0] op, input logic rd,
                                     input logic [2:0] idx, input logic [7:0] d);
    logic [63:0] w = '0;
    w[63] = v; w[62:60] = op; w[56] = rd; w[42:40] = idx; w[7:0] = d;
    return w;
  endfunction

  function automatic logic [63:0] vis(input logic [63:0] w);
    return mk(w[63], w[62:60], w[56], w[42:40], w[7:0]);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [63:0] w);
    logic [63:0] v = vis(w);
    logic acc = w[63] && w[62:60] == 3'd6;
    @(negedge clk); host_we = 1'b1; host_wdata = w;
    @(negedge clk); host_we = 1'b0;
    if (acc) begin
      chk("R3 start high c1", 64'(host_rdata[63]), 64'd1);
      chk(w[56] ? "R5 rd strobe" : "R4 wr strobe", {61'd0, reg_wr, reg_rd, 1'b0},
          {61'd0, !w[56], w[56], 1'b0});
      chk("R4 sel/wdata", {53'd0, reg_sel, reg_wdata}, {53'd0, w[42:40], w[7:0]});
      @(negedge clk);
      chk("R3 start high c2 no strobe", {62'd0, host_rdata[63], reg_wr | reg_rd}, {62'd0, 2'b10});
      @(negedge clk);
      if (!w[56]) shadow[w[42:40]] = w[7:0];
      chk(w[56] ? "R5 read result" : "R4 write done",
          host_rdata, mk(1'b0, w[62:60], w[56], w[42:40], w[56] ? shadow[w[42:40]] : w[7:0]));
    end else begin
      chk(w[63] ? "R6 other op word" : "R7 idle write word", host_rdata,
          w[63] ? mk(1'b0, w[62:60], w[56], w[42:40], 8'h00) : v);
      chk(w[63] ? "R6 no strobe" : "R7 no strobe", {62'd0, reg_wr, reg_rd}, 64'd0);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin rf[i] = 8'(i * 17 + 3); shadow[i] = 8'(i * 17 + 3); end
    repeat (3) @(negedge clk);
    chk("R1 reset word", host_rdata, 64'd0);
    chk("R1 reset strobes", {62'd0, reg_wr, reg_rd}, 64'd0);
    rst_n = 1'b1;
    // R4 then R5 directed, highest index
    run_cmd(mk(1, 3'd6, 0, 3'd7, 8'hA5));
    run_cmd(mk(1, 3'd6, 1, 3'd7, 8'h00));
    run_cmd(mk(1, 3'd6, 1, 3'd0, 8'hFF));
    // R2: stray bits read back as zero
    run_cmd(64'h0FF0_F0FF_0F0F_F05A);
    run_cmd(64'hFFFF_FFFF_FFFF_FFFF & ~64'h0800_0000_0000_0000 | 64'h0000_0000_0000_0000);
    // R6 other opcodes
    run_cmd(mk(1, 3'd0, 1, 3'd2, 8'h33));
    run_cmd(mk(1, 3'd7, 0, 3'd5, 8'h44));
    // R8: write during busy ignored
    begin
      @(negedge clk); host_we = 1'b1; host_wdata = mk(1, 3'd6, 0, 3'd3, 8'h5C);
      @(negedge clk); host_wdata = mk(1, 3'd6, 1, 3'd6, 8'h99);
      @(negedge clk); host_wdata = mk(0, 3'd1, 0, 3'd1, 8'h11);
      @(negedge clk); host_we = 1'b0;
      shadow[3] = 8'h5C;
      chk("R8 busy write ignored", host_rdata, mk(0, 3'd6, 0, 3'd3, 8'h5C));
      chk("R8 no second strobe", {62'd0, reg_wr, reg_rd}, 64'd0);
      run_cmd(mk(1, 3'd6, 1, 3'd6, 8'h00));
    end
    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [63:0] w = {$urandom, $urandom};
      if ($urandom % 4 != 0) begin w[63] = 1'b1; w[62:60] = 3'd6; end
      run_cmd(w);
    end
    for (int i = 0; i < 8; i++) run_cmd(mk(1, 3'd6, 1, 3'(i), 8'h00));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule